// File: doc/BRIEF.md
# Programmable-Length SPI Master Word Engine

This block is a single-channel SPI master. It moves one word of 4 to 32 bits per transfer. Word length, transfer direction, chip-select guard time, a one-time start-up delay and the serial clock rate are plain configuration inputs. The core clock runs at twice the reference rate, so a serial-clock half period always lasts a whole number of core cycles.

Software-facing logic writes a word through a data bus with a one-cycle write strobe. It reads back the received word, and then acknowledges it with a read strobe. Three status outputs pace that exchange: the transmit register is free, a received word is waiting, and a word has finished.

The serial clock idles low. The master changes MOSI on falling edges and samples MISO on rising edges, most significant bit first. Chip select is active low and frames each word.

Top module: `spi_word_master`

## Requirements
- R1: `wl_code` gives the word length minus one, so N = `wl_code`+1. Exactly N rising serial-clock edges occur per word. MOSI carries bits N-1 down to 0 of the written word in that order, stable at each rising edge. `sclk` is low whenever `cs_n` is high.
- R2: A word never starts while `wl_code` is 0, 1 or 2, or while `mode` is 3. In that case `cs_n` stays high and a pending written word keeps `tx_empty` low.
- R3: With `clk_gran`=0, every serial-clock half period lasts 2^`div_code` core cycles. With `clk_gran`=1, it lasts {`div_ext`,`div_code`}+1 core cycles.
- R4: Let g be the value of `guard`. The time from `cs_n` falling to the first rising edge is (2g+1) half periods. The time from the last falling edge to `cs_n` rising is also (2g+1) half periods.
- R5: The first word after `en` rises waits 2·P half periods before `cs_n` falls, where P = 4, 8, 16 or 32 for `init_code` 1 to 4. Codes 0 and 5 to 7 add no wait. During the wait `cs_n` stays high and `sclk` stays low. Later words add no wait. Without a wait, `cs_n` falls two cycles after the cycle in which `tx_wr` is high.
- R6: In transmit-and-receive mode (`mode`=0), the N bits sampled on MISO appear right-aligned on `rx_data` with the upper bits zero, and `rx_full` goes high. While `rx_full` is high, no new word starts. `rx_rd` clears `rx_full`.
- R7: In receive-only mode (`mode`=1), a word starts whenever `en` is high and `rx_full` is low, without a write. MOSI is held low, and the received word is delivered as in R6.
- R8: In transmit-only mode (`mode`=2), `rx_full` never rises, and the next word starts as soon as a new word is written.
- R9: `tx_empty` falls on `tx_wr` and rises when a word is taken into the shift register. It never falls without `tx_wr`.
- R10: `eow` is a single-cycle pulse. It is asserted in the first cycle with `cs_n` high again after a word.
- R11: After reset, `cs_n`=1, `sclk`=0, `mosi`=0, `tx_empty`=1, `rx_full`=0 and `eow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (twice the reference rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel enable; a rising edge re-arms the start-up delay |
| wl_code | input | 5 | Word length minus one (3..31 valid) |
| mode | input | 2 | 0 transmit+receive, 1 receive only, 2 transmit only, 3 reserved |
| guard | input | 2 | Chip-select guard code, (2g+1) half periods |
| init_code | input | 3 | Start-up delay code |
| clk_gran | input | 1 | 0 power-of-two divider, 1 linear divider |
| div_code | input | 4 | Divider field |
| div_ext | input | 8 | Divider extension, used when `clk_gran`=1 |
| tx_data | input | 32 | Word to transmit, right-aligned |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| rx_rd | input | 1 | Acknowledge of the received word |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low chip select |
| tx_empty | output | 1 | Transmit register free |
| rx_full | output | 1 | Received word waiting |
| rx_data | output | 32 | Received word, right-aligned |
| eow | output | 1 | End-of-word pulse |

## Verification
The bench targets the edges of the configuration space:
- 4-bit and 32-bit words. An off-by-one in the length decode would add or drop a bit, or shift the whole word.
- Divider ratio 1 and ratio 4096. A design that counts one cycle too many or too few would skew every half period.
- Guard codes 0 and 3. Without the (2g+1) half-period rule, the lead or trail window would come out a whole period off.
- The start-up delay, checked on the first word after enable and again on the word after it. A delay that does not re-arm, or that repeats, would show at once.
- Receive mode with `rx_full` still set. A design that ignores the unread word would overwrite it and start a frame early.
- Reserved length and mode codes. A design that does not block them would raise `cs_n` activity and clear `tx_empty`.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } wm_state_e;

    localparam logic [1:0] MODE_TXRX = 2'd0;
    localparam logic [1:0] MODE_RX   = 2'd1;
    localparam logic [1:0] MODE_TX   = 2'd2;
    localparam logic [1:0] MODE_RSVD = 2'd3;

endpackage

// File: rtl/spi_wm_ratio.sv
// Half-period length in core cycles, minus one, from the divider fields.
module spi_wm_ratio #(
    parameter int DIVW = 4,
    parameter int EXTW = 8,
    parameter int CNTW = 16
) (
    input  logic            gran,
    input  logic [DIVW-1:0] div,
    input  logic [EXTW-1:0] ext,
    output logic [CNTW-1:0] reload
);
    always_comb begin
        if (gran) begin
            // linear: ratio = {ext,div} + 1, so ratio-1 is the field itself
            reload = CNTW'({ext, div});
        end else begin
            // power of two: ratio = 2**div
            reload = (CNTW'(1) << div) - CNTW'(1);
        end
    end
endmodule

// File: rtl/spi_wm_phases.sv
// Number of half periods spent in each framing phase.
module spi_wm_phases #(
    parameter int WLW   = 5,
    parameter int HALFW = 7
) (
    input  logic [1:0]       guard,
    input  logic [2:0]       init_code,
    input  logic [WLW-1:0]   wl,
    output logic [HALFW-1:0] guard_h,
    output logic [HALFW-1:0] init_h,
    output logic [HALFW-1:0] shift_h
);
    always_comb begin
        guard_h = HALFW'({guard, 1'b1});          // 2g+1
        shift_h = HALFW'({wl, 1'b1});             // 2N-1 with N = wl+1
        unique case (init_code)
            3'd1, 3'd2, 3'd3, 3'd4: init_h = HALFW'(4) << init_code;  // 2*P
            default:                init_h = '0;
        endcase
    end
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spi_wm_pkg::*;
#(
    parameter int WMAX = 32,
    parameter int DIVW = 4,
    parameter int EXTW = 8,
    localparam int WLW = $clog2(WMAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [WLW-1:0]  wl_code,
    input  logic [1:0]      mode,
    input  logic [1:0]      guard,
    input  logic [2:0]      init_code,
    input  logic            clk_gran,
    input  logic [DIVW-1:0] div_code,
    input  logic [EXTW-1:0] div_ext,
    input  logic [WMAX-1:0] tx_data,
    input  logic            tx_wr,
    input  logic            rx_rd,
    input  logic            miso,
    output logic            sclk,
    output logic            mosi,
    output logic            cs_n,
    output logic            tx_empty,
    output logic            rx_full,
    output logic [WMAX-1:0] rx_data,
    output logic            eow
);
    localparam int CNTW  = (2**DIVW > DIVW + EXTW) ? 2**DIVW : DIVW + EXTW;
    localparam int HALFW = $clog2(2 * WMAX + 1);

    typedef struct packed {
        wm_state_e        state;
        logic [CNTW-1:0]  cnt;
        logic [HALFW-1:0] half;
        logic             sclk;
        logic             cs_n;
        logic [WMAX-1:0]  sh;
        logic [WMAX-1:0]  rx_sh;
        logic [WMAX-1:0]  tx_buf;
        logic [WMAX-1:0]  rx_data;
        logic             tx_empty;
        logic             rx_full;
        logic             eow;
        logic             first;
    } wm_regs_t;

    wm_regs_t q, d;

    logic [CNTW-1:0]  reload;
    logic [HALFW-1:0] guard_h, init_h, shift_h;
    logic             tick, last, cfg_ok, want;

    spi_wm_ratio #(.DIVW(DIVW), .EXTW(EXTW), .CNTW(CNTW)) u_ratio (
        .gran   (clk_gran),
        .div    (div_code),
        .ext    (div_ext),
        .reload (reload)
    );

    spi_wm_phases #(.WLW(WLW), .HALFW(HALFW)) u_phases (
        .guard     (guard),
        .init_code (init_code),
        .wl        (wl_code),
        .guard_h   (guard_h),
        .init_h    (init_h),
        .shift_h   (shift_h)
    );

    always_comb begin
        d      = q;
        d.eow  = 1'b0;
        tick   = (q.cnt == '0);
        last   = tick && (q.half == HALFW'(1));
        cfg_ok = (wl_code >= WLW'(3)) && (mode != MODE_RSVD);
        want   = (mode == MODE_RX) ? !q.rx_full
                                   : (!q.tx_empty && !((mode == MODE_TXRX) && q.rx_full));

        if (!en)   d.first   = 1'b1;
        if (rx_rd) d.rx_full = 1'b0;

        // shared half-period timer
        if (q.state != ST_IDLE) begin
            if (tick) begin
                d.cnt  = reload;
                d.half = q.half - HALFW'(1);
            end else begin
                d.cnt  = q.cnt - CNTW'(1);
            end
        end

        unique case (q.state)
            ST_IDLE: begin
                if (en && cfg_ok && want) begin
                    d.sh    = (mode == MODE_RX) ? '0
                                                : (q.tx_buf << (WLW'(WMAX - 1) - wl_code));
                    d.rx_sh = '0;
                    d.cnt   = reload;
                    d.first = 1'b0;
                    if (mode != MODE_RX) d.tx_empty = 1'b1;
                    if (q.first && (init_h != '0)) begin
                        d.state = ST_INIT;
                        d.half  = init_h;
                    end else begin
                        d.state = ST_LEAD;
                        d.cs_n  = 1'b0;
                        d.half  = guard_h;
                    end
                end
            end
            ST_INIT: begin
                if (last) begin
                    d.state = ST_LEAD;
                    d.cs_n  = 1'b0;
                    d.half  = guard_h;
                end
            end
            ST_LEAD: begin
                if (last) begin
                    d.state = ST_SHIFT;
                    d.sclk  = 1'b1;
                    d.rx_sh = {q.rx_sh[WMAX-2:0], miso};
                    d.half  = shift_h;
                end
            end
            ST_SHIFT: begin
                if (last) begin
                    d.sclk  = 1'b0;
                    d.state = ST_TRAIL;
                    d.half  = guard_h;
                end else if (tick) begin
                    if (q.sclk) begin
                        d.sclk = 1'b0;
                        d.sh   = q.sh << 1;
                    end else begin
                        d.sclk  = 1'b1;
                        d.rx_sh = {q.rx_sh[WMAX-2:0], miso};
                    end
                end
            end
            ST_TRAIL: begin
                if (last) begin
                    d.state = ST_IDLE;
                    d.cs_n  = 1'b1;
                    d.eow   = 1'b1;
                    d.sh    = '0;
                    if (mode != MODE_TX) begin
                        d.rx_full = 1'b1;
                        d.rx_data = q.rx_sh;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (tx_wr) begin
            d.tx_buf   = tx_data;
            d.tx_empty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cnt: '0, half: '0, sclk: 1'b0, cs_n: 1'b1,
                   sh: '0, rx_sh: '0, tx_buf: '0, rx_data: '0, tx_empty: 1'b1,
                   rx_full: 1'b0, eow: 1'b0, first: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign sclk     = q.sclk;
    assign mosi     = q.sh[WMAX-1];
    assign cs_n     = q.cs_n;
    assign tx_empty = q.tx_empty;
    assign rx_full  = q.rx_full;
    assign rx_data  = q.rx_data;
    assign eow      = q.eow;

endmodule

// File: rtl/spi_wm_chk.sv
module spi_wm_chk #(
    parameter int WLW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic [WLW-1:0] wl_code,
    input logic [1:0]     mode,
    input logic           tx_wr,
    input logic           sclk,
    input logic           cs_n,
    input logic           tx_empty,
    input logic           rx_full,
    input logic           eow
);
    p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_rise_framed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !cs_n);

    p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(wl_code) >= WLW'(3) && $past(mode) != 2'd3));

    p_hold_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !($past(rx_full) && $past(mode) == 2'd0));

    p_txonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> ($past(mode) != 2'd2 && eow));

    p_txempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(tx_wr));

    p_eow_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eow |-> cs_n);

    p_eow_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eow |=> !eow);
endmodule

bind spi_word_master spi_wm_chk #(.WLW(WLW)) u_chk (.*);

// File: tb/tb_spi_word_master.sv
module tb_spi_word_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [4:0]  wl_code = 5'd7;
    logic [1:0]  mode = 2'd2;
    logic [1:0]  guard = 2'd0;
    logic [2:0]  init_code = 3'd0;
    logic        clk_gran = 1'b0;
    logic [3:0]  div_code = 4'd0;
    logic [7:0]  div_ext = 8'd0;
    logic [31:0] tx_data = '0;
    logic        tx_wr = 1'b0;
    logic        rx_rd = 1'b0;
    logic        miso = 1'b0;
    logic        sclk, mosi, cs_n, tx_empty, rx_full, eow;
    logic [31:0] rx_data;

    always #5 clk = ~clk;

    spi_word_master dut (
        .clk(clk), .rst_n(rst_n), .en(en), .wl_code(wl_code), .mode(mode),
        .guard(guard), .init_code(init_code), .clk_gran(clk_gran),
        .div_code(div_code), .div_ext(div_ext), .tx_data(tx_data),
        .tx_wr(tx_wr), .rx_rd(rx_rd), .miso(miso), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .tx_empty(tx_empty), .rx_full(rx_full),
        .rx_data(rx_data), .eow(eow)
    );

    int n_chk = 0;
    int n_bad = 0;

    // monitor and slave model, sampling away from the active edge
    int cyc = 0;
    int t_wr, t_csf, t_csr, t_r1, t_lf, t_le, t_eow;
    int nbits, bad_half, eow_cnt, cs_falls, exp_r, sn, k;
    bit got_rise;
    logic [31:0] cap, sw;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;

    initial begin
        t_wr = 0; t_csf = 0; t_csr = 0; t_r1 = 0; t_lf = 0; t_le = 0; t_eow = 0;
        nbits = 0; bad_half = 0; eow_cnt = 0; cs_falls = 0; exp_r = 1; sn = 8; k = 0;
        got_rise = 1'b0; cap = '0; sw = '0;
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (tx_wr) t_wr = cyc;
        if (prev_cs && !cs_n) begin
            t_csf = cyc; cs_falls = cs_falls + 1; got_rise = 1'b0;
            miso = sw[sn-1]; k = sn - 2;
        end
        if (!prev_sclk && sclk) begin
            if (!got_rise) begin t_r1 = cyc; got_rise = 1'b1; end
            else if (cyc - t_le != exp_r) bad_half = bad_half + 1;
            cap = {cap[30:0], mosi}; nbits = nbits + 1; t_le = cyc;
        end
        if (prev_sclk && !sclk) begin
            if (cyc - t_le != exp_r) bad_half = bad_half + 1;
            t_le = cyc; t_lf = cyc;
            if (k >= 0) begin miso = sw[k]; k = k - 1; end
        end
        if (!prev_cs && cs_n) t_csr = cyc;
        if (eow) begin eow_cnt = eow_cnt + 1; t_eow = cyc; end
        prev_sclk = sclk; prev_cs = cs_n;
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int rexp(input bit g, input int dv, input int ex);
        return g ? (ex * 16 + dv + 1) : (1 << dv);
    endfunction

    function automatic int inith(input int c);
        return (c >= 1 && c <= 4) ? (4 << c) : 0;
    endfunction

    function automatic logic [31:0] wmask(input int n);
        return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    task automatic clear_mon();
        nbits = 0; cap = '0; bad_half = 0; eow_cnt = 0;
    endtask

    task automatic wait_eow();
        int w = 0;
        while (eow_cnt == 0 && w < 60000) begin step(1); w++; end
        chk(eow_cnt != 0, "R10", "end of word seen", eow_cnt, 1);
        step(2);
    endtask

    task automatic rearm();
        en = 1'b0; step(1); en = 1'b1;
    endtask

    task automatic run_word(input int m, input int wl, input int g,
                            input logic [31:0] data, input logic [31:0] slv,
                            input bit do_wr, input bit first);
        int n = wl + 1;
        int r = rexp(clk_gran, int'(div_code), int'(div_ext));
        logic [31:0] exp_tx;
        mode = 2'(m); wl_code = 5'(wl); guard = 2'(g);
        exp_r = r; sw = slv; sn = n;
        clear_mon();
        if (do_wr) begin
            tx_data = data; tx_wr = 1'b1; step(1); tx_wr = 1'b0;
        end
        wait_eow();
        exp_tx = (m == 1) ? 32'h0 : (data & wmask(n));
        chk(nbits == n, "R1", "rising edge count", nbits, n);
        chk(cap == exp_tx, (m == 1) ? "R7" : "R1", "mosi word", cap, exp_tx);
        chk(bad_half == 0, "R3", "half-period errors", bad_half, 0);
        chk(t_r1 - t_csf == (2*g+1)*r, "R4", "lead guard", t_r1 - t_csf, (2*g+1)*r);
        chk(t_csr - t_lf == (2*g+1)*r, "R4", "trail guard", t_csr - t_lf, (2*g+1)*r);
        if (do_wr && m != 1)
            chk(t_csf - t_wr == 2 + (first ? inith(int'(init_code)) * r : 0), "R5",
                "write to cs fall", t_csf - t_wr,
                2 + (first ? inith(int'(init_code)) * r : 0));
        chk(eow_cnt == 1 && t_eow == t_csr, "R10", "eow pulse at cs rise",
            t_eow, t_csr);
        chk(tx_empty == 1'b1, "R9", "tx_empty after word", tx_empty, 1);
        if (m == 2) begin
            chk(rx_full == 1'b0, "R8", "rx_full in tx-only", rx_full, 0);
        end else begin
            chk(rx_full == 1'b1, "R6", "rx_full set", rx_full, 1);
            chk(rx_data == (slv & wmask(n)), (m == 1) ? "R7" : "R6", "rx_data",
                rx_data, slv & wmask(n));
            if (m == 1) mode = 2'd2;
            rx_rd = 1'b1; step(1); rx_rd = 1'b0; step(1);
            chk(rx_full == 1'b0, "R6", "rx_full cleared by read", rx_full, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        int cf;
        seed = $urandom(32'd4711);
        step(5);
        // R11 reset state
        chk(cs_n == 1'b1,     "R11", "cs_n", cs_n, 1);
        chk(sclk == 1'b0,     "R11", "sclk", sclk, 0);
        chk(mosi == 1'b0,     "R11", "mosi", mosi, 0);
        chk(tx_empty == 1'b1, "R11", "tx_empty", tx_empty, 1);
        chk(rx_full == 1'b0,  "R11", "rx_full", rx_full, 0);
        chk(eow == 1'b0,      "R11", "eow", eow, 0);
        rst_n = 1'b1; step(2);
        en = 1'b1; step(2);

        // R1 basic 8-bit transmit-only word, ratio 1
        run_word(2, 7, 0, 32'hA5, 32'h0, 1'b1, 1'b1);
        // R5 start-up delay, first word and the one after
        init_code = 3'd4; rearm();
        run_word(0, 3, 1, 32'h9, 32'h6, 1'b1, 1'b1);
        run_word(0, 3, 1, 32'h5, 32'hA, 1'b1, 1'b0);
        init_code = 3'd6; rearm();
        run_word(2, 15, 2, 32'hBEEF, 32'h0, 1'b1, 1'b1);
        init_code = 3'd0;

        // R2 reserved length and mode codes
        cf = cs_falls;
        mode = 2'd2; wl_code = 5'd2;
        tx_data = 32'h3C; tx_wr = 1'b1; step(1); tx_wr = 1'b0;
        step(200);
        chk(cs_falls == cf, "R2", "no frame with length code 2", cs_falls, cf);
        chk(tx_empty == 1'b0, "R2", "word kept pending", tx_empty, 0);
        mode = 2'd3; wl_code = 5'd7; step(200);
        chk(cs_falls == cf, "R2", "no frame with mode 3", cs_falls, cf);
        chk(tx_empty == 1'b0, "R2", "word kept pending in mode 3", tx_empty, 0);
        run_word(2, 7, 0, 32'h3C, 32'h0, 1'b0, 1'b0);

        // R6 unread word holds off the next one
        mode = 2'd0; wl_code = 5'd11; guard = 2'd0;
        exp_r = 1; sw = 32'h5A3; sn = 12; clear_mon();
        tx_data = 32'h123; tx_wr = 1'b1; step(1); tx_wr = 1'b0;
        wait_eow();
        cf = cs_falls;
        tx_data = 32'hABC; tx_wr = 1'b1; step(1); tx_wr = 1'b0;
        step(100);
        chk(cs_falls == cf, "R6", "no start while rx_full", cs_falls, cf);
        chk(tx_empty == 1'b0, "R6", "second word still pending", tx_empty, 0);
        chk(rx_data == 32'h5A3, "R6", "first received word", rx_data, 32'h5A3);
        clear_mon(); sw = 32'h0F0;
        rx_rd = 1'b1; step(1); rx_rd = 1'b0;
        wait_eow();
        chk(cap == 32'hABC, "R6", "held word sent after read", cap, 32'hABC);
        chk(rx_data == 32'h0F0, "R6", "second received word", rx_data, 32'h0F0);
        rx_rd = 1'b1; step(1); rx_rd = 1'b0; step(1);

        // R1 length extremes, R3 largest linear ratio, R7 receive-only
        run_word(0, 31, 3, 32'hDEADBEEF, 32'hC0FFEE11, 1'b1, 1'b0);
        run_word(1, 9, 1, 32'h0, 32'h2D5, 1'b0, 1'b0);
        clk_gran = 1'b1; div_ext = 8'hFF; div_code = 4'hF;
        run_word(2, 3, 0, 32'hE, 32'h0, 1'b1, 1'b0);
        div_ext = 8'h01; div_code = 4'h2;
        run_word(0, 4, 0, 32'h15, 32'h0A, 1'b1, 1'b0);
        div_ext = 8'h00;
        // R8 back-to-back transmit-only
        clk_gran = 1'b0; div_code = 4'd1;
        run_word(2, 7, 1, 32'h11, 32'h0, 1'b1, 1'b0);
        run_word(2, 7, 1, 32'h22, 32'h0, 1'b1, 1'b0);

        // randomized words over all modes, lengths, guards and dividers
        for (int i = 0; i < 30; i++) begin
            int m  = int'($urandom_range(0, 2));
            int wl = int'($urandom_range(3, 31));
            int g  = int'($urandom_range(0, 3));
            bit ra = ($urandom_range(0, 3) == 0);
            clk_gran  = 1'($urandom_range(0, 1));
            div_code  = clk_gran ? 4'($urandom_range(0, 15)) : 4'($urandom_range(0, 4));
            init_code = 3'($urandom_range(0, 7));
            if (ra) rearm();
            run_word(m, wl, g, $urandom, $urandom, m != 1, ra);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule